// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the general-purpose register storage of a 32-bit integer core that uses overlapping register windows. Instructions name one of 32 architectural registers with a 5-bit number. The block turns that number into an index in a physical array, using the current window pointer (the window pointer). Eight global registers are shared by all windows. Each window adds sixteen physical registers: eight locals that only that window can see, and eight outs. The outs of one window are the ins of its neighbour, so arguments placed in outs before a call appear as ins inside the callee, and nothing has to be copied.

There are two combinational read ports and one write port that updates on the clock edge. The window count `NWIN` is a parameter from 2 to 32, and the physical array holds 16·NWIN+8 registers. Two inputs move the pointer: `win_save` for a call and `win_restore` for a return. The pointer wraps modulo `NWIN` in both directions. The pointer controller has three named operations, chosen each cycle from those two inputs:
- WIN_HOLD keeps the pointer.
- WIN_SAVE decrements it, and the wrap from 0 goes to NWIN-1.
- WIN_RESTORE increments it, and the wrap from NWIN-1 goes to 0.

All operations return to the same decision on the next cycle. The block has no other state beyond the pointer and the storage.

Top module: `regwin_rf`

## Requirements
- R1: After reset the window pointer is 0 and every architectural register reads as 0.
- R2: Architectural numbers 0–7 select the globals. A global written from one window reads back with the same value from any other window, on both read ports.
- R3: Register number 0 always reads as 0, and a write to it changes nothing.
- R4: Numbers 16–23 select the locals, which are private to the window. A local written in one window is not seen, and not altered, when the same number is used in another window.
- R5: Numbers 8–15 select the outs and 24–31 select the ins. In window w, the in with number 24+k is the same storage as the out with number 8+k of window (w+1) mod NWIN. This includes the wrap between window NWIN-1 and window 0.
- R6: Operation selection:
  - `win_save` alone selects WIN_SAVE, and the pointer becomes (cwp-1) mod NWIN.
  - `win_restore` alone selects WIN_RESTORE, and the pointer becomes (cwp+1) mod NWIN.
  - Both inputs high, or both low, select WIN_HOLD.
- R7: A pointer change takes effect on the clock edge. Reads and a write issued in the same cycle as a save or restore use the old window.
- R8: Each read port returns, without a clock, the register named by its own address. The two ports are independent.
- R9: A write updates storage at the clock edge. A read of the same register in the write cycle returns the old value, and the new value is readable from the next cycle.
- R10: The window pointer is always less than NWIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_save | input | 1 | Move to the next window down (call) |
| win_restore | input | 1 | Move to the next window up (return) |
| cwp | output | $clog2(NWIN) | Current window pointer |
| rd_a_addr | input | 5 | Read port A architectural number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 5 | Read port B architectural number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural number |
| wr_data | input | 32 | Write data |

## Verification
The checker assumes the inputs are already synchronous to `clk`. Its write-visibility property also assumes that a write counts only when no window move happens in the same cycle, because a move changes which storage the next cycle's address names. The bench therefore changes all inputs half a cycle away from the rising edge. It issues writes in hold cycles, except in the one scenario that deliberately combines a write with a save to show that the old window is used. Addresses are always full 5-bit numbers, and the pointer is moved only through the two inputs. Every pointer value the checker sees is then reached through legal steps.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int XLEN    = 32;
    localparam int ARCH_AW = 5;

    // Operation applied to the window pointer in a cycle
    typedef enum logic [1:0] {
        WIN_HOLD    = 2'd0,
        WIN_SAVE    = 2'd1,
        WIN_RESTORE = 2'd2
    } win_op_e;

    // Register class decoded from the two top bits of the architectural number
    typedef enum logic [1:0] {
        RC_GLOBAL = 2'd0,
        RC_OUT    = 2'd1,
        RC_LOCAL  = 2'd2,
        RC_IN     = 2'd3
    } reg_class_e;
endpackage

// File: rtl/regwin_cwp.sv
module regwin_cwp
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_save,
    input  logic          win_restore,
    output logic [CW-1:0] cwp
);
    localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

    win_op_e       op;
    logic [CW-1:0] cwp_q;
    logic [CW-1:0] cwp_d;

    // Operation decode: both or neither input means hold (R6)
    always_comb begin
        op = WIN_HOLD;
        if (win_save && !win_restore) op = WIN_SAVE;
        if (win_restore && !win_save) op = WIN_RESTORE;
    end

    // Next pointer with modulo wrap (R6, R10)
    always_comb begin
        cwp_d = cwp_q;
        unique case (op)
            WIN_HOLD:    cwp_d = cwp_q;
            WIN_SAVE:    cwp_d = (cwp_q == '0) ? TOP : cwp_q - CW'(1);
            WIN_RESTORE: cwp_d = (cwp_q == TOP) ? '0 : cwp_q + CW'(1);
            default:     cwp_d = cwp_q;
        endcase
    end

    // Pointer register (R1, R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cwp_q <= '0;
        else        cwp_q <= cwp_d;
    end

    assign cwp = cwp_q;
endmodule

// File: rtl/regwin_map.sv
module regwin_map
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW   = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int PHYS = 16 * NWIN + 8,
    localparam int PA   = $clog2(PHYS)
) (
    input  logic [CW-1:0]      cwp,
    input  logic [ARCH_AW-1:0] arch,
    output logic [PA-1:0]      phys
);
    reg_class_e cls;
    int         win_base;
    int         up_base;
    int         up_win;
    int         idx;

    assign cls = reg_class_e'(arch[4:3]);

    always_comb begin
        // Window w owns locals at base+0..7 and outs at base+8..15
        up_win   = (int'(cwp) == NWIN - 1) ? 0 : int'(cwp) + 1;
        win_base = 8 + 16 * int'(cwp);
        up_base  = 8 + 16 * up_win;
        idx      = 0;
        unique case (cls)
            RC_GLOBAL: idx = int'(arch[2:0]);
            RC_OUT:    idx = win_base + 8 + int'(arch[2:0]);
            RC_LOCAL:  idx = win_base + int'(arch[2:0]);
            RC_IN:     idx = up_base + 8 + int'(arch[2:0]);  // R5: outs of w+1
            default:   idx = 0;
        endcase
        phys = PA'(idx);
    end
endmodule

// File: rtl/regwin_array.sv
module regwin_array
    import regwin_pkg::*;
#(
    parameter int DEPTH = 136,
    localparam int PA   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PA-1:0]   ra_idx,
    output logic [XLEN-1:0] ra_data,
    input  logic [PA-1:0]   rb_idx,
    output logic [XLEN-1:0] rb_data,
    input  logic            we,
    input  logic [PA-1:0]   w_idx,
    input  logic [XLEN-1:0] w_data
);
    logic [XLEN-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[w_idx] <= w_data;
        end
    end

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];
endmodule

// File: rtl/regwin_rf.sv
module regwin_rf
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW   = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int PHYS = 16 * NWIN + 8,
    localparam int PA   = $clog2(PHYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_save,
    input  logic               win_restore,
    output logic [CW-1:0]      cwp,
    input  logic [ARCH_AW-1:0] rd_a_addr,
    output logic [XLEN-1:0]    rd_a_data,
    input  logic [ARCH_AW-1:0] rd_b_addr,
    output logic [XLEN-1:0]    rd_b_data,
    input  logic               wr_en,
    input  logic [ARCH_AW-1:0] wr_addr,
    input  logic [XLEN-1:0]    wr_data
);
    logic [PA-1:0]   pa_a, pa_b, pa_w;
    logic [XLEN-1:0] raw_a, raw_b;
    logic            we_eff;

    regwin_cwp #(.NWIN(NWIN)) u_cwp (
        .clk(clk), .rst_n(rst_n),
        .win_save(win_save), .win_restore(win_restore),
        .cwp(cwp)
    );

    regwin_map #(.NWIN(NWIN)) u_map_a (.cwp(cwp), .arch(rd_a_addr), .phys(pa_a));
    regwin_map #(.NWIN(NWIN)) u_map_b (.cwp(cwp), .arch(rd_b_addr), .phys(pa_b));
    regwin_map #(.NWIN(NWIN)) u_map_w (.cwp(cwp), .arch(wr_addr),   .phys(pa_w));

    // Writes to register 0 are dropped (R3)
    assign we_eff = wr_en && (wr_addr != '0);

    regwin_array #(.DEPTH(PHYS)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(pa_a), .ra_data(raw_a),
        .rb_idx(pa_b), .rb_data(raw_b),
        .we(we_eff), .w_idx(pa_w), .w_data(wr_data)
    );

    assign rd_a_data = (rd_a_addr == '0) ? '0 : raw_a;
    assign rd_b_data = (rd_b_addr == '0) ? '0 : raw_b;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               win_save,
    input logic               win_restore,
    input logic [CW-1:0]      cwp,
    input logic [ARCH_AW-1:0] rd_a_addr,
    input logic [XLEN-1:0]    rd_a_data,
    input logic [ARCH_AW-1:0] rd_b_addr,
    input logic [XLEN-1:0]    rd_b_data,
    input logic               wr_en,
    input logic [ARCH_AW-1:0] wr_addr,
    input logic [XLEN-1:0]    wr_data
);
    localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

    AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cwp) < NWIN); // R10

    AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (win_save && !win_restore) |=>
        (cwp == (($past(cwp) == '0) ? TOP : $past(cwp) - CW'(1)))); // R6

    AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (win_restore && !win_save) |=>
        (cwp == (($past(cwp) == TOP) ? '0 : $past(cwp) + CW'(1)))); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_save == win_restore) |=> $stable(cwp)); // R6

    AST_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0) |-> (rd_a_data == '0)); // R3

    AST_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_addr == '0) |-> (rd_b_data == '0)); // R3

    AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && win_save == win_restore) |=>
        ((rd_a_addr != $past(wr_addr)) || (rd_a_data == $past(wr_data)))); // R9
endmodule

bind regwin_rf regwin_chk #(.NWIN(NWIN)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .win_save(win_save), .win_restore(win_restore), .cwp(cwp),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/tb_regwin_rf.sv
module tb_regwin_rf;
    localparam int NWIN = 8;
    localparam int CW   = $clog2(NWIN);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          win_save = 1'b0, win_restore = 1'b0;
    logic [CW-1:0] cwp;
    logic [4:0]    rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [31:0]   rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_cwp = 0;
    bit done = 0;

    regwin_rf #(.NWIN(NWIN)) dut (
        .clk(clk), .rst_n(rst_n),
        .win_save(win_save), .win_restore(win_restore), .cwp(cwp),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rda(input logic [4:0] a, input logic [31:0] exp, input string tag);
        rd_a_addr = a;
        #1;
        chk(tag, rd_a_data, exp);
    endtask

    task automatic save();
        win_save = 1'b1; tick(); win_save = 1'b0;
        exp_cwp = (exp_cwp == 0) ? NWIN - 1 : exp_cwp - 1;
    endtask

    task automatic restore();
        win_restore = 1'b1; tick(); win_restore = 1'b0;
        exp_cwp = (exp_cwp == NWIN - 1) ? 0 : exp_cwp + 1;
    endtask

    task automatic t_reset();
        chk("R1 cwp after reset", 32'(cwp), 0);
        for (int r = 0; r < 32; r++) rda(5'(r), 0, "R1 register after reset");
    endtask

    task automatic t_zero();
        wr(5'd0, 32'hDEAD_BEEF);
        rda(5'd0, 0, "R3 g0 read after write");
        rd_b_addr = 5'd0; #1;
        chk("R3 g0 port B", rd_b_data, 0);
    endtask

    task automatic t_globals();
        for (int g = 1; g < 8; g++) wr(5'(g), 32'h0000_0100 + 32'(g));
        save();
        save();
        for (int g = 1; g < 8; g++) begin
            rd_a_addr = 5'(g); rd_b_addr = 5'(8 - g); #1;
            chk("R2 global port A other window", rd_a_data, 32'h100 + 32'(g));
            chk("R8 global port B independent", rd_b_data, 32'h100 + 32'(8 - g));
        end
    endtask

    task automatic t_locals();
        for (int w = 0; w < NWIN; w++) begin
            wr(5'd19, 32'h5A00_0000 | 32'(exp_cwp));
            restore();
        end
        for (int w = 0; w < NWIN; w++) begin
            rda(5'd19, 32'h5A00_0000 | 32'(exp_cwp), "R4 local private per window");
            restore();
        end
    endtask

    task automatic t_alias();
        // out written, save, same value read as in; covers wrap 0 -> NWIN-1
        for (int w = 0; w < NWIN; w++) begin
            wr(5'd10, 32'hC0DE_0000 | 32'(exp_cwp));
            save();
            chk("R6 cwp after save", 32'(cwp), 32'(exp_cwp));
            rda(5'd26, 32'hC0DE_0000 | 32'((exp_cwp + 1) % NWIN), "R5 out->in after save");
        end
        // in written, restore, same value read as out; covers wrap NWIN-1 -> 0
        for (int w = 0; w < NWIN; w++) begin
            wr(5'd29, 32'hBEEF_0000 | 32'(exp_cwp));
            restore();
            chk("R6 cwp after restore", 32'(cwp), 32'(exp_cwp));
            rda(5'd13, 32'hBEEF_0000 | 32'((exp_cwp + NWIN - 1) % NWIN), "R5 in->out after restore");
        end
        chk("R10 cwp in range", 32'(int'(cwp) < NWIN), 1);
    endtask

    task automatic t_move_timing();
        int old_c;
        old_c = exp_cwp;
        win_save = 1'b1; wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h7777_0001;
        #1;
        chk("R7 cwp unchanged in move cycle", 32'(cwp), 32'(old_c));
        tick();
        win_save = 1'b0; wr_en = 1'b0;
        exp_cwp = (exp_cwp == 0) ? NWIN - 1 : exp_cwp - 1;
        chk("R7 cwp changed after edge", 32'(cwp), 32'(exp_cwp));
        rda(5'd25, 32'h7777_0001, "R7 write used old window");
        win_save = 1'b1; win_restore = 1'b1;
        tick();
        win_save = 1'b0; win_restore = 1'b0;
        chk("R6 both inputs hold", 32'(cwp), 32'(exp_cwp));
    endtask

    task automatic t_same_cycle();
        wr(5'd17, 32'h1111_1111);
        rd_a_addr = 5'd17;
        wr_en = 1'b1; wr_addr = 5'd17; wr_data = 32'h2222_2222;
        #1;
        chk("R9 old value during write cycle", rd_a_data, 32'h1111_1111);
        tick();
        wr_en = 1'b0;
        #1;
        chk("R9 new value next cycle", rd_a_data, 32'h2222_2222);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_globals();
        t_locals();
        t_alias();
        t_move_timing();
        t_same_cycle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule